// File: doc/BRIEF.md
# Serial EEPROM Slave with Transfer Pause

This block models the slave side of a small serial EEPROM that sits on a four-wire serial bus. A byte-wide storage array of 256 locations and a status byte sit behind a command engine. The engine takes opcodes, an address byte and data from SI on rising SCK and returns data on SO after falling SCK. All pins are sampled by a fast system clock, so SCK is treated as a slow data signal and every action happens on a system clock edge.

A write is not stored while the bus is still active. It is armed during the frame and starts when chip select rises. A modelled internal write cycle then keeps a busy flag set for a fixed number of system clocks. An active-low protect input can still abort an armed write at any time before chip select rises. An active-low pause input freezes a transfer in the middle of a bit sequence and later lets it continue at the exact next bit.

Top module: `spi_eeprom_hold`

## Requirements
- R1: While `cs_n` is high the block ignores `sck` and `si`, and `so_oe` is low from the clock after `cs_n` is seen high.
- R2: Bits are taken on rising `sck` only after `cs_n` is low. A `cs_n` falling edge that happens while `sck` is high is not counted as a bit.
- R3: The opcodes are 0x06 set write-enable, 0x04 clear write-enable, 0x05 read status, 0x01 write status, 0x03 read and 0x02 write. The status byte is {4'b0000, guard[1:0], wel, wip}, with wip at bit 0 and wel at bit 1, and it reads 0x00 after reset.
- R4: A read is opcode 0x03 followed by an address byte. The addressed byte then comes out MSB first, one bit per falling `sck`, and further bytes follow from incrementing addresses. The array reads 0xFF after reset.
- R5: A write is opcode 0x02, an address byte and exactly one whole data byte. It is stored when `cs_n` rises, but only if wel is set. If wel is clear, the frame is cut short, or more than one data byte was sent, nothing is stored and no busy cycle starts.
- R6: A write-status command is opcode 0x01 and one data byte. Under the same wel condition it loads guard[1:0] from data bits [3:2].
- R7: After a write or write-status starts, wip reads 1 for `BUSY_CYCLES` system clocks. When it ends, wel clears.
- R8: While wip is 1, every opcode other than 0x05 is ignored. A read then drives nothing and a write stores nothing.
- R9: `wp_n` low at any moment between `cs_n` falling and `cs_n` rising cancels a pending write or write-status. wel is left unchanged.
- R10: Once the internal write has started, `wp_n` has no effect on it.
- R11: Pause is entered when `hold_n` is low while `sck` is low, and it is left when `hold_n` is high while `sck` is low. During pause `so_oe` is low and `sck` and `si` are ignored. A low pulse on `hold_n` that falls and rises while `sck` is high has no effect.
- R12: After a pause is released, the transfer continues at the exact bit where it stopped, in the address phase as well as in the data phase.
- R13: Raising `cs_n` during a pause aborts the command. The next frame starts clean and memory is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the bus master |
| si | input | 1 | Serial data into the block |
| wp_n | input | 1 | Write protect, active low; cancels a pending write |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so`; low means high impedance |

## Verification
A wrong bit position or byte count shows up within one byte time. It appears either as a shifted status or read byte on SO, or as a write that lands at the wrong address or does not land at all, which the next read reveals. A wrong wel or cancel flag shows in the status byte of the very next read-status frame. A wrong busy length shows up when the status is polled right after the write and again after `BUSY_CYCLES`. A fault in the pause logic shows up within a bit time, either as an enabled SO during the pause or as one byte slipped by one bit after release.

// File: rtl/spi_eeprom_hold_pkg.sv
package spi_eeprom_hold_pkg;
  localparam logic [7:0] OP_NONE  = 8'h00;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  // Status byte layout: guard bits, enable latch, busy flag.
  function automatic logic [7:0] status_word(input logic [1:0] guard,
                                             input logic wel, input logic wip);
    return {4'b0000, guard, wel, wip};
  endfunction

  // Byte counter that sticks at its top value.
  function automatic logic [2:0] count_up_sat(input logic [2:0] n);
    return (n == 3'd7) ? n : n + 3'd1;
  endfunction
endpackage

// File: rtl/spi_eeprom_hold_front.sv
module spi_eeprom_hold_front (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic hold_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise,
  output logic hold_act
);
  logic sck_q, cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      cs_q     <= 1'b1;
      hold_act <= 1'b0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_n)      hold_act <= 1'b0;
      else if (!sck) hold_act <= !hold_n;
    end
  end

  assign sck_rise = sck & ~sck_q & ~cs_n & ~cs_q & ~hold_act;
  assign sck_fall = ~sck & sck_q & ~cs_n & ~hold_act;
  assign cs_rise  = cs_n & ~cs_q;
endmodule

// File: rtl/spi_eeprom_hold_store.sv
module spi_eeprom_hold_store #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/spi_eeprom_hold_timer.sv
module spi_eeprom_hold_timer #(
  parameter int CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left <= '0;
    else if (start)        left <= CW'(CYCLES);
    else if (left != '0)   left <= left - CW'(1);
  end

  assign busy = (left != '0);
  assign done = (left == CW'(1));
endmodule

// File: rtl/spi_eeprom_hold.sv
module spi_eeprom_hold #(
  parameter int ADDR_W      = 8,
  parameter int BUSY_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic wp_n,
  input  logic hold_n,
  output logic so,
  output logic so_oe
);
  import spi_eeprom_hold_pkg::*;

  logic              sck_rise, sck_fall, cs_rise, hold_act;
  logic              busy, tmr_done, start_wr, frame_ok;
  logic [2:0]        bitpos, nbytes;
  logic [6:0]        shin;
  logic [7:0]        byte_in, opcode, wdata, outsh, rd_data, status;
  logic [ADDR_W-1:0] addr, rd_addr;
  logic [1:0]        guard;
  logic              wel, cancel, rd_mode, drive_q, so_q;

  spi_eeprom_hold_front u_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise), .hold_act(hold_act)
  );

  spi_eeprom_hold_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(start_wr && opcode == OP_WRITE),
    .waddr(addr), .wdata(wdata), .raddr(rd_addr), .rdata(rd_data)
  );

  spi_eeprom_hold_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start_wr), .busy(busy), .done(tmr_done)
  );

  assign byte_in  = {shin, si};
  assign status   = status_word(guard, wel, busy);
  assign rd_addr  = (nbytes == 3'd1) ? byte_in[ADDR_W-1:0] : addr;
  assign frame_ok = (bitpos == 3'd0) &&
                    ((opcode == OP_WRITE && nbytes == 3'd3) ||
                     (opcode == OP_WRSR  && nbytes == 3'd2));
  assign start_wr = cs_rise && frame_ok && wel && !cancel && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitpos <= '0; nbytes <= '0; shin <= '0; opcode <= OP_NONE;
      addr <= '0; wdata <= '0; outsh <= '0; guard <= '0;
      wel <= 1'b0; cancel <= 1'b0; rd_mode <= 1'b0; drive_q <= 1'b0; so_q <= 1'b0;
    end else begin
      if (tmr_done) wel <= 1'b0;
      if (start_wr && opcode == OP_WRSR) guard <= wdata[3:2];
      if (cs_n) begin
        bitpos  <= '0;
        nbytes  <= '0;
        opcode  <= OP_NONE;
        rd_mode <= 1'b0;
        drive_q <= 1'b0;
        cancel  <= 1'b0;
      end else begin
        if (!wp_n) cancel <= 1'b1;
        if (sck_rise) begin
          shin   <= byte_in[6:0];
          bitpos <= bitpos + 3'd1;
          if (bitpos == 3'd7) begin
            nbytes <= count_up_sat(nbytes);
            if (nbytes == 3'd0) begin
              if (!busy || byte_in == OP_RDSR) opcode <= byte_in;
              if (!busy && byte_in == OP_WREN) wel <= 1'b1;
              if (!busy && byte_in == OP_WRDI) wel <= 1'b0;
              if (byte_in == OP_RDSR) begin
                outsh   <= status;
                rd_mode <= 1'b1;
              end
            end else begin
              case (opcode)
                OP_READ: begin
                  outsh   <= rd_data;
                  addr    <= rd_addr + {{(ADDR_W-1){1'b0}}, 1'b1};
                  rd_mode <= 1'b1;
                end
                OP_RDSR:  outsh <= status;
                OP_WRITE: begin
                  if (nbytes == 3'd1)      addr  <= byte_in[ADDR_W-1:0];
                  else if (nbytes == 3'd2) wdata <= byte_in;
                end
                OP_WRSR:  if (nbytes == 3'd1) wdata <= byte_in;
                default: ;
              endcase
            end
          end
        end
        if (sck_fall && rd_mode) begin
          so_q    <= outsh[7];
          outsh   <= {outsh[6:0], 1'b0};
          drive_q <= 1'b1;
        end
      end
    end
  end

  assign so    = so_q;
  assign so_oe = drive_q & ~hold_act;
endmodule

// File: rtl/spi_eeprom_hold_checks.sv
module spi_eeprom_hold_checks #(
  parameter int BUSY_CYCLES = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       so,
  input logic       so_oe,
  input logic       hold_act,
  input logic [2:0] bitpos,
  input logic       sck_fall,
  input logic       busy,
  input logic       start_wr
);
  int busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= 0;
  end

  assert_oe_off_in_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !so_oe);

  assert_so_moves_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(so) |-> $past(sck_fall));

  assert_start_enters_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> busy);

  assert_busy_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run < BUSY_CYCLES));

  assert_hold_freezes_position_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_act && !cs_n) |=> $stable(bitpos));
endmodule

bind spi_eeprom_hold spi_eeprom_hold_checks #(.BUSY_CYCLES(BUSY_CYCLES)) u_checks (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so(so), .so_oe(so_oe),
  .hold_act(hold_act), .bitpos(bitpos), .sck_fall(sck_fall),
  .busy(busy), .start_wr(start_wr)
);

// File: tb/spi_eeprom_hold_bench.sv
module spi_eeprom_hold_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int BUSY       = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1, hold_n = 1'b1;
  logic so, so_oe;
  int checks = 0, fails = 0, mon_fails = 0;
  logic oe_seen = 1'b0, cs_prev = 1'b1, finished = 1'b0;
  logic [7:0] exp_mem [256];
  logic [7:0] s, d0, d1;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_eeprom_hold #(.ADDR_W(8), .BUSY_CYCLES(BUSY)) u_spi_eeprom_hold (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .wp_n(wp_n), .hold_n(hold_n), .so(so), .so_oe(so_oe)
  );

  // Standby monitor, every clock (R1)
  always @(negedge clk) begin
    if (rst_n && cs_n && cs_prev && so_oe) mon_fails++;
    cs_prev = cs_n;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic spi_bit(input logic b, output logic r);
    si = b;
    repeat (HALF) @(negedge clk);
    r = so;
    if (so_oe) oe_seen = 1'b1;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      spi_bit(tx[i], b);
      rx[i] = b;
    end
  endtask

  task automatic sel;
    cs_n = 1'b0; oe_seen = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic desel;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] junk;
    sel; xfer(op, junk); desel;
  endtask

  task automatic rd_status(output logic [7:0] st);
    logic [7:0] junk;
    sel; xfer(8'h05, junk); xfer(8'h00, st); desel;
  endtask

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] v);
    logic [7:0] junk;
    sel; xfer(8'h02, junk); xfer(a, junk); xfer(v, junk); desel;
  endtask

  task automatic rd_byte(input logic [7:0] a, output logic [7:0] v);
    logic [7:0] junk;
    sel; xfer(8'h03, junk); xfer(a, junk); xfer(8'h00, v); desel;
  endtask

  task automatic pause(input string tag);
    hold_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      si = ~si; sck = 1'b1;
      repeat (HALF) @(negedge clk);
      chk(tag, so_oe, 0);
      sck = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    hold_n = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] junk, v;
    logic b;
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    chk("R1 reset so_oe", so_oe, 0);
    rd_status(s);  chk("R3 status after reset", s, 8'h00);
    rd_byte(8'h10, v); chk("R4 erased read", v, exp_mem[8'h10]);

    cmd1(8'h06); rd_status(s); chk("R3 wel set", s, 8'h02);
    wr_byte(8'h10, 8'hA5); exp_mem[8'h10] = 8'hA5;
    rd_status(s); chk("R7 wip during write", s, 8'h03);
    repeat (BUSY) @(negedge clk);
    rd_status(s); chk("R7 idle and wel cleared", s, 8'h00);
    rd_byte(8'h10, v); chk("R4 read back", v, exp_mem[8'h10]);

    cmd1(8'h06); wr_byte(8'h11, 8'h3C); exp_mem[8'h11] = 8'h3C;
    repeat (BUSY + 100) @(negedge clk);
    sel; xfer(8'h03, junk); xfer(8'h10, junk); xfer(8'h00, d0); xfer(8'h00, d1); desel;
    chk("R4 sequential first", d0, exp_mem[8'h10]);
    chk("R4 sequential second", d1, exp_mem[8'h11]);

    wr_byte(8'h20, 8'h77);
    rd_status(s); chk("R5 no wel no busy", s, 8'h00);
    rd_byte(8'h20, v); chk("R5 no wel no store", v, exp_mem[8'h20]);

    cmd1(8'h06);
    sel; xfer(8'h02, junk); xfer(8'h20, junk); xfer(8'h11, junk); xfer(8'h22, junk); desel;
    rd_status(s); chk("R5 two data bytes rejected", s, 8'h02);
    sel; xfer(8'h02, junk); xfer(8'h20, junk);
    for (int i = 0; i < 7; i++) spi_bit(1'b0, b);
    desel;
    rd_status(s); chk("R5 partial byte rejected", s, 8'h02);
    rd_byte(8'h20, v); chk("R5 memory untouched", v, exp_mem[8'h20]);

    sel; xfer(8'h02, junk); xfer(8'h20, junk); wp_n = 1'b0; xfer(8'h55, junk); wp_n = 1'b1; desel;
    rd_status(s); chk("R9 write cancelled wel kept", s, 8'h02);
    rd_byte(8'h20, v); chk("R9 cancelled write not stored", v, exp_mem[8'h20]);

    wr_byte(8'h20, 8'h55); exp_mem[8'h20] = 8'h55;
    wp_n = 1'b0;
    rd_status(s); chk("R10 write runs despite wp", s, 8'h03);
    wp_n = 1'b1;
    repeat (BUSY) @(negedge clk);
    rd_byte(8'h20, v); chk("R10 stored", v, exp_mem[8'h20]);

    cmd1(8'h06); wr_byte(8'h21, 8'h66); exp_mem[8'h21] = 8'h66;
    wr_byte(8'h22, 8'h99);
    sel; xfer(8'h03, junk); xfer(8'h21, junk); xfer(8'h00, junk); desel;
    chk("R8 read ignored while busy", oe_seen, 0);
    repeat (BUSY) @(negedge clk);
    rd_byte(8'h22, v); chk("R8 write ignored while busy", v, exp_mem[8'h22]);
    rd_byte(8'h21, v); chk("R5 first write stored", v, exp_mem[8'h21]);

    cmd1(8'h06);
    sel; xfer(8'h01, junk); xfer(8'h0C, junk); desel;
    repeat (BUSY + 10) @(negedge clk);
    rd_status(s); chk("R6 guard bits loaded", s, 8'h0C);
    cmd1(8'h06);
    sel; xfer(8'h01, junk); wp_n = 1'b0; xfer(8'h00, junk); desel; wp_n = 1'b1;
    rd_status(s); chk("R9 status write cancelled", s, 8'h0E);
    cmd1(8'h04); rd_status(s); chk("R3 wel cleared", s, 8'h0C);

    for (int i = 7; i >= 0; i--) begin
      si = 1'(8'h06 >> i); sck = 1'b1; repeat (HALF) @(negedge clk);
      sck = 1'b0; repeat (HALF) @(negedge clk);
    end
    rd_status(s); chk("R1 standby ignores sck si", s, 8'h0C);

    sck = 1'b1; si = 1'b1; repeat (HALF) @(negedge clk);
    cs_n = 1'b0; oe_seen = 1'b0; repeat (HALF) @(negedge clk);
    sck = 1'b0;
    xfer(8'h05, junk); xfer(8'h00, s); desel;
    chk("R2 cs fall with sck high", s, 8'h0C);

    cmd1(8'h06); wr_byte(8'h30, 8'hC6); exp_mem[8'h30] = 8'hC6;
    repeat (BUSY + 10) @(negedge clk);
    sel; xfer(8'h03, junk);
    for (int i = 7; i >= 5; i--) spi_bit(1'(8'h30 >> i), b);
    pause("R11 addr pause so off");
    for (int i = 4; i >= 0; i--) spi_bit(1'(8'h30 >> i), b);
    for (int i = 7; i >= 5; i--) begin spi_bit(1'b0, b); v[i] = b; end
    chk("R11 so driven before pause", oe_seen, 1);
    pause("R11 data pause so off");
    si = 1'b0; repeat (HALF) @(negedge clk);
    v[4] = so; sck = 1'b1; repeat (1) @(negedge clk);
    hold_n = 1'b0; repeat (1) @(negedge clk); hold_n = 1'b1;
    repeat (HALF - 2) @(negedge clk); sck = 1'b0;
    for (int i = 3; i >= 0; i--) begin spi_bit(1'b0, b); v[i] = b; end
    chk("R11 glitch with sck high ignored", so_oe, 1);
    desel;
    chk("R12 resumed at exact bit", v, exp_mem[8'h30]);

    sel; xfer(8'h03, junk);
    for (int i = 0; i < 4; i++) spi_bit(1'b1, b);
    hold_n = 1'b0; repeat (HALF) @(negedge clk);
    cs_n = 1'b1; repeat (HALF) @(negedge clk);
    hold_n = 1'b1; repeat (HALF) @(negedge clk);
    rd_status(s); chk("R13 clean frame after abort", s, 8'h0C);
    rd_byte(8'h30, v); chk("R13 memory unchanged", v, exp_mem[8'h30]);

    chk("R1 standby monitor", mon_fails, 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule